// File: doc/BRIEF.md
# Logic Unit with Carry Rotates

This block is the bitwise and rotate stage of a DSP data path. Each accepted operation takes a destination register value, a source operand and the current carry flag. The destination register is wider than the data word. The low word of the destination register and the source word are the two operands. The block returns the updated register image, a new carry, and zero and negative flags for the new low word.

Only the low word of the destination changes. The portion above it is copied through unchanged, so the register file can write the whole register back without masking. Results are registered and appear one clock after the operation is accepted. When no operation is offered, every output keeps its last value.

Top module: `lu_core`

## Requirements
- R1: Opcode 3'b000 yields dst AND src, 3'b010 yields dst OR src, and 3'b100 yields dst XOR src in the low word of the result. Here dst is the low word of the destination input and src is the source input.
- R2: Opcode 3'b001 yields dst AND (NOT src), and opcode 3'b011 yields dst OR (NOT src).
- R3: Opcode 3'b101 yields NOT src.
- R4: Opcode 3'b111 rotates src left by one bit through carry. The old carry enters bit 0, and the old bit WORD_W-1 becomes the new carry.
- R5: Opcode 3'b110 rotates src right by one bit through carry. The old carry enters bit WORD_W-1, and the old bit 0 becomes the new carry.
- R6: Opcodes 3'b000 through 3'b101 clear the carry output.
- R7: The bits of the result above the low word equal the same bits of the destination input at the cycle the operation was accepted.
- R8: The zero flag is 1 exactly when the result low word is all zeros. The negative flag equals bit WORD_W-1 of the result low word.
- R9: The result valid output is high in the cycle after each cycle with op_valid high, and low otherwise. While op_valid is low, the result, carry and flags hold their values.
- R10: After reset, res_valid, res_word, carry_out, zero_flag and neg_flag are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is offered this cycle |
| op_code | input | 3 | Operation select (encodings in R1 to R6) |
| dst_word | input | WORD_W+UPPER_W | Full destination register; its low word is an operand |
| src_word | input | WORD_W | Source operand |
| carry_in | input | 1 | Current carry flag |
| res_valid | output | 1 | Result registers were loaded on the last edge |
| res_word | output | WORD_W+UPPER_W | Updated destination register image |
| carry_out | output | 1 | Updated carry flag |
| zero_flag | output | 1 | Result low word is zero |
| neg_flag | output | 1 | Result low word sign bit |

## Verification
The assertions check the following on every cycle: the one-cycle valid latency, the holding of outputs while idle, the pass-through of the upper register bits, carry clearing on non-rotate operations, the carry taken from the bit that leaves a rotate, and agreement of both flags with the stored word. The exact low-word value of each of the eight operations is shown only by the bench. It sweeps every opcode over a grid of operand patterns and both carry values, and compares each result against arithmetic written independently of the RTL. The bench also shows the reset state and the hold behaviour under changing idle inputs.

// File: rtl/lu_pkg.sv
package lu_pkg;

  typedef enum logic [2:0] {
    LU_AND  = 3'b000,
    LU_ANDN = 3'b001,
    LU_OR   = 3'b010,
    LU_ORN  = 3'b011,
    LU_XOR  = 3'b100,
    LU_NOT  = 3'b101,
    LU_ROR  = 3'b110,
    LU_ROL  = 3'b111
  } lu_op_e;

  function automatic logic op_is_rotate(input lu_op_e op);
    return (op == LU_ROR) || (op == LU_ROL);
  endfunction

endpackage

// File: rtl/lu_bitwise.sv
module lu_bitwise
  import lu_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  lu_op_e            op,
  input  logic [WORD_W-1:0] dst,
  input  logic [WORD_W-1:0] src,
  output logic [WORD_W-1:0] y
);

  function automatic logic [WORD_W-1:0] bitwise_fn(
    input lu_op_e            f_op,
    input logic [WORD_W-1:0] f_dst,
    input logic [WORD_W-1:0] f_src
  );
    logic [WORD_W-1:0] inv_src;
    inv_src = ~f_src;
    case (f_op)
      LU_AND:  return f_dst & f_src;
      LU_ANDN: return f_dst & inv_src;
      LU_OR:   return f_dst | f_src;
      LU_ORN:  return f_dst | inv_src;
      LU_XOR:  return f_dst ^ f_src;
      LU_NOT:  return inv_src;
      default: return '0;
    endcase
  endfunction

  assign y = bitwise_fn(op, dst, src);

endmodule

// File: rtl/lu_rotate.sv
module lu_rotate #(
  parameter int WORD_W = 32
) (
  input  logic              go_left,
  input  logic [WORD_W-1:0] src,
  input  logic              cin,
  output logic [WORD_W-1:0] y,
  output logic              cout
);

  function automatic logic [WORD_W:0] rot_left_fn(
    input logic [WORD_W-1:0] v,
    input logic              c
  );
    return {v, c};
  endfunction

  function automatic logic [WORD_W:0] rot_right_fn(
    input logic [WORD_W-1:0] v,
    input logic              c
  );
    return {v[0], c, v[WORD_W-1:1]};
  endfunction

  logic [WORD_W:0] left_r;
  logic [WORD_W:0] right_r;

  assign left_r  = rot_left_fn(src, cin);
  assign right_r = rot_right_fn(src, cin);

  assign cout = go_left ? left_r[WORD_W]     : right_r[WORD_W];
  assign y    = go_left ? left_r[WORD_W-1:0] : right_r[WORD_W-1:0];

endmodule

// File: rtl/lu_flags.sv
module lu_flags #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] y,
  output logic              zero,
  output logic              neg
);

  assign zero = (y == '0);
  assign neg  = y[WORD_W-1];

endmodule

// File: rtl/lu_core.sv
module lu_core
  import lu_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int UPPER_W = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        op_valid,
  input  logic [2:0]                  op_code,
  input  logic [WORD_W+UPPER_W-1:0]   dst_word,
  input  logic [WORD_W-1:0]           src_word,
  input  logic                        carry_in,
  output logic                        res_valid,
  output logic [WORD_W+UPPER_W-1:0]   res_word,
  output logic                        carry_out,
  output logic                        zero_flag,
  output logic                        neg_flag
);

  localparam int FULL_W = WORD_W + UPPER_W;

  lu_op_e            op;
  logic [WORD_W-1:0] dst_low;
  logic [WORD_W-1:0] logic_y;
  logic [WORD_W-1:0] rot_y;
  logic              rot_c;
  logic              is_rotate;
  logic              is_left;
  logic [WORD_W-1:0] next_low;
  logic              next_c;
  logic              next_zero;
  logic              next_neg;

  assign op        = lu_op_e'(op_code);
  assign dst_low   = dst_word[WORD_W-1:0];
  assign is_rotate = op_is_rotate(op);
  assign is_left   = (op == LU_ROL);

  lu_bitwise #(.WORD_W(WORD_W)) u_bitwise (
    .op  (op),
    .dst (dst_low),
    .src (src_word),
    .y   (logic_y)
  );

  lu_rotate #(.WORD_W(WORD_W)) u_rotate (
    .go_left (is_left),
    .src     (src_word),
    .cin     (carry_in),
    .y       (rot_y),
    .cout    (rot_c)
  );

  assign next_low = is_rotate ? rot_y : logic_y;
  assign next_c   = is_rotate & rot_c;

  lu_flags #(.WORD_W(WORD_W)) u_flags (
    .y    (next_low),
    .zero (next_zero),
    .neg  (next_neg)
  );

  logic [WORD_W-1:0]  low_q;
  logic [UPPER_W-1:0] upper_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      low_q     <= '0;
      upper_q   <= '0;
      carry_out <= 1'b0;
      zero_flag <= 1'b0;
      neg_flag  <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        low_q     <= next_low;
        upper_q   <= dst_word[FULL_W-1:WORD_W];
        carry_out <= next_c;
        zero_flag <= next_zero;
        neg_flag  <= next_neg;
      end
    end
  end

  assign res_word = {upper_q, low_q};

  // R9: valid latency
  p_valid_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid) else $error("p_valid_follow_r9");
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid) else $error("p_valid_idle_r9");
  // R9: hold while idle
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(res_word) && $stable(carry_out) && $stable(zero_flag)
                   && $stable(neg_flag))) else $error("p_hold_r9");
  // R7: upper pass-through
  p_upper_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_word[FULL_W-1:WORD_W] == $past(dst_word[FULL_W-1:WORD_W]))
    else $error("p_upper_pass_r7");
  // R6: carry cleared by logical ops
  p_carry_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !is_rotate) |=> !carry_out) else $error("p_carry_clear_r6");
  // R4: rotate-left carry
  p_rol_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == LU_ROL) |=> carry_out == $past(src_word[WORD_W-1]))
    else $error("p_rol_carry_r4");
  // R5: rotate-right carry
  p_ror_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op == LU_ROR) |=> carry_out == $past(src_word[0]))
    else $error("p_ror_carry_r5");
  // R8: flags agree with stored word
  p_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (zero_flag == (low_q == '0)) && (neg_flag == low_q[WORD_W-1]))
    else $error("p_flags_r8");

endmodule

// File: tb/sim_lu_core.sv
module sim_lu_core;

  localparam int CLK_PERIOD = 10;
  localparam int W  = 32;
  localparam int UW = 64;
  localparam int FW = W + UW;
  localparam int NPAT = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [2:0]    op_code = '0;
  logic [FW-1:0] dst_word = '0;
  logic [W-1:0]  src_word = '0;
  logic          carry_in = 1'b0;
  logic          res_valid;
  logic [FW-1:0] res_word;
  logic          carry_out;
  logic          zero_flag;
  logic          neg_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lu_core #(.WORD_W(W), .UPPER_W(UW)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .dst_word(dst_word), .src_word(src_word), .carry_in(carry_in),
    .res_valid(res_valid), .res_word(res_word), .carry_out(carry_out),
    .zero_flag(zero_flag), .neg_flag(neg_flag)
  );

  logic [W-1:0] pats [NPAT];

  task automatic check(input string req, input string what,
                       input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [W:0] model(input logic [2:0] op, input logic [W-1:0] d,
                                       input logic [W-1:0] s, input logic c);
    logic [W-1:0] ns;
    ns = s ^ {W{1'b1}};
    case (op)
      3'd0: model = {1'b0, d & s};
      3'd1: model = {1'b0, d & ns};
      3'd2: model = {1'b0, d | s};
      3'd3: model = {1'b0, d | ns};
      3'd4: model = {1'b0, d ^ s};
      3'd5: model = {1'b0, ns};
      3'd6: model = {s[0], (s >> 1) | (W'(c) << (W-1))};
      default: model = {s[W-1], (s << 1) | W'(c)};
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0, 3'd2, 3'd4: return "R1";
      3'd1, 3'd3: return "R2";
      3'd5: return "R3";
      3'd6: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic run_op(input logic [2:0] op, input logic [W-1:0] d,
                        input logic [UW-1:0] up, input logic [W-1:0] s, input logic c);
    logic [W:0] e;
    @(negedge clk);
    op_valid = 1'b1; op_code = op; dst_word = {up, d}; src_word = s; carry_in = c;
    @(negedge clk);
    op_valid = 1'b0;
    e = model(op, d, s, c);
    check(req_of(op), "low word", FW'(res_word[W-1:0]), FW'(e[W-1:0]));
    check(op < 3'd6 ? "R6" : req_of(op), "carry", FW'(carry_out), FW'(e[W]));
    check("R7", "upper", FW'(res_word[FW-1:W]), FW'(up));
    check("R8", "zero", FW'(zero_flag), FW'(e[W-1:0] == '0));
    check("R8", "neg", FW'(neg_flag), FW'(e[W-1]));
    check("R9", "valid", FW'(res_valid), FW'(1'b1));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lf;
    logic [FW-1:0] held;
    logic held_c;
    pats[0] = '0; pats[1] = '1; pats[2] = 32'h8000_0000; pats[3] = 32'h1;
    pats[4] = 32'hAAAA_AAAA; pats[5] = 32'h5555_5555;
    lf = 32'h1234_5678;
    for (int i = 6; i < NPAT; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]} * 32'd2654435761 + 32'd7;
      pats[i] = lf;
    end

    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R10: reset state
    check("R10", "valid", FW'(res_valid), '0);
    check("R10", "word", res_word, '0);
    check("R10", "carry", FW'(carry_out), '0);
    check("R10", "zero", FW'(zero_flag), '0);
    check("R10", "neg", FW'(neg_flag), '0);
    rst_n = 1'b1;

    for (int op = 0; op < 8; op++)
      for (int a = 0; a < NPAT; a++)
        for (int b = 0; b < NPAT; b++)
          for (int c = 0; c < 2; c++)
            run_op(3'(op), pats[a], {pats[b], pats[(a + b) % NPAT]}, pats[b], c[0]);

    // R9: hold while idle with changing inputs
    run_op(3'd7, 32'h0, 64'hDEAD_BEEF_0000_1111, 32'h8000_0001, 1'b1);
    held = res_word; held_c = carry_out;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      op_valid = 1'b0; op_code = 3'(k); dst_word = {UW'(k), pats[k]};
      src_word = pats[k + 4]; carry_in = k[0];
      @(negedge clk);
      check("R9", "idle valid", FW'(res_valid), '0);
      check("R9", "idle word", res_word, held);
      check("R9", "idle carry", FW'(carry_out), FW'(held_c));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule